// File: doc/BRIEF.md
# Banked Nibble Register File

This block holds the programmer-visible state of a small 4-bit processor core: an accumulator with its carry flag, a status flag, a sub-accumulator that also serves as a counter, and two address pointers. One pointer selects a RAM file. The other selects a RAM digit and a single-bit I/O terminal. Each pointer has a shadow register that it can trade places with in one operation. The shadow register can hold a saved pointer or act as an upper address extension.

An external decoder drives one command bit per cycle, and an external ALU supplies a result nibble and an overflow bit. The accumulator and carry can take the ALU result together. They can also rotate as one 5-bit ring in either direction. The carry can be forced to 1 or 0, or copied into the status flag. The digit pointer can count up or down by itself while its current value drives the bus, so multi-digit loops need no separate pointer update step. Every register appears on an output port at all times.

Top module: `nib_regbank`

## Requirements
- R1: An active-low reset clears all six nibble registers, the carry and the status flag to 0.
- R2: Command bit 0 loads `alu_res_i` into the accumulator and `alu_ovf_i` into the carry on the same edge.
- R3: Command bits 1, 2 and 3 load `alu_res_i` into the sub-accumulator, the file pointer and the digit pointer respectively, and change nothing else.
- R4: Command bit 8 sets the carry to 1, bit 9 clears it to 0, and bit 10 copies the carry into the status flag; the accumulator is unchanged by all three.
- R5: Command bit 6 rotates the carry and accumulator left: the new accumulator is its old bits 2..0 with the old carry in bit 0, and the new carry is the old bit 3. Command bit 7 is the mirror: the new accumulator is the old carry in bit 3 followed by old bits 3..1, and the new carry is the old bit 0.
- R6: Command bit 4 swaps the file pointer and its shadow; both old values survive.
- R7: Command bit 5 swaps the digit pointer and its shadow; both old values survive.
- R8: Command bit 11 increments and bit 12 decrements the digit pointer modulo 16. Throughout the cycle that carries the command, `y_o` shows the old value, and the new value appears after the edge.
- R9: When no command bit is set, or when more than one is set, no register or flag changes.
- R10: A command leaves every register and flag that it does not name unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 13 | One-hot command strobes, bit positions as listed in the requirements |
| alu_res_i | input | 4 | ALU result nibble |
| alu_ovf_i | input | 1 | ALU overflow bit |
| a_o | output | 4 | Accumulator |
| c_o | output | 1 | Carry flag |
| s_o | output | 1 | Status flag |
| b_o | output | 4 | Sub-accumulator / counter |
| x_o | output | 4 | RAM file pointer |
| spx_o | output | 4 | File pointer shadow |
| y_o | output | 4 | RAM digit and I/O pointer |
| spy_o | output | 4 | Digit pointer shadow |

## Verification
The bench builds the block with its default nibble width of four. At that width a short run reaches the pointer wrap from 15 to 0 and back, and a few rotations carry a set bit fully around the 5-bit carry ring. The command sequence sets up differing values in each pointer and its shadow before swapping them, so a lost or duplicated value shows up. Rejection of multi-bit commands is checked with combinations whose individual effects would each be visible.

// File: rtl/nib_regbank_pkg.sv
package nib_regbank_pkg;

    // Command strobe positions (one-hot)
    localparam int CMD_LD_A  = 0;
    localparam int CMD_LD_B  = 1;
    localparam int CMD_LD_X  = 2;
    localparam int CMD_LD_Y  = 3;
    localparam int CMD_XCH_X = 4;
    localparam int CMD_XCH_Y = 5;
    localparam int CMD_ROT_L = 6;
    localparam int CMD_ROT_R = 7;
    localparam int CMD_SET_C = 8;
    localparam int CMD_CLR_C = 9;
    localparam int CMD_TST_C = 10;
    localparam int CMD_INC_Y = 11;
    localparam int CMD_DEC_Y = 12;
    localparam int CMD_N     = 13;

endpackage

// File: rtl/nib_acc_unit.sv
module nib_acc_unit #(
    parameter int NIB_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_i,
    input  logic [NIB_W-1:0] res_i,
    input  logic             ovf_i,
    input  logic             rot_l_i,
    input  logic             rot_r_i,
    input  logic             set_c_i,
    input  logic             clr_c_i,
    input  logic             tst_c_i,
    output logic [NIB_W-1:0] a_o,
    output logic             c_o,
    output logic             s_o
);

    localparam int MSB = NIB_W - 1;

    typedef struct packed {
        logic [NIB_W-1:0] acc;
        logic             cy;
        logic             st;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.acc = res_i;
            st_d.cy  = ovf_i;
        end
        if (rot_l_i) begin
            st_d.acc = {st_q.acc[MSB-1:0], st_q.cy};
            st_d.cy  = st_q.acc[MSB];
        end
        if (rot_r_i) begin
            st_d.acc = {st_q.cy, st_q.acc[MSB:1]};
            st_d.cy  = st_q.acc[0];
        end
        if (set_c_i) begin
            st_d.cy = 1'b1;
        end
        if (clr_c_i) begin
            st_d.cy = 1'b0;
        end
        if (tst_c_i) begin
            st_d.st = st_q.cy;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_o = st_q.acc;
    assign c_o = st_q.cy;
    assign s_o = st_q.st;

endmodule

// File: rtl/nib_ptr_pair.sv
module nib_ptr_pair #(
    parameter int NIB_W   = 4,
    parameter bit STEP_EN = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_i,
    input  logic [NIB_W-1:0] res_i,
    input  logic             xch_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [NIB_W-1:0] ptr_o,
    output logic [NIB_W-1:0] shd_o
);

    typedef struct packed {
        logic [NIB_W-1:0] ptr;
        logic [NIB_W-1:0] shd;
    } pair_state_t;

    pair_state_t      st_d, st_q;
    logic [NIB_W-1:0] step_nx;
    logic             step_req;

    generate
        if (STEP_EN) begin : g_step
            always_comb begin
                step_req = inc_i | dec_i;
                if (inc_i) begin
                    step_nx = st_q.ptr + NIB_W'(1);
                end else if (dec_i) begin
                    step_nx = st_q.ptr - NIB_W'(1);
                end else begin
                    step_nx = st_q.ptr;
                end
            end
        end else begin : g_nostep
            logic step_unused;
            assign step_unused = inc_i ^ dec_i;
            assign step_req    = 1'b0;
            assign step_nx     = st_q.ptr;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.ptr = res_i;
        end
        if (xch_i) begin
            st_d.ptr = st_q.shd;
            st_d.shd = st_q.ptr;
        end
        if (step_req) begin
            st_d.ptr = step_nx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
    assign shd_o = st_q.shd;

endmodule

// File: rtl/nib_plain_reg.sv
module nib_plain_reg #(
    parameter int NIB_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_i,
    input  logic [NIB_W-1:0] res_i,
    output logic [NIB_W-1:0] val_o
);

    logic [NIB_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (ld_i) begin
            val_d = res_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/nib_regbank.sv
module nib_regbank
    import nib_regbank_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CMD_N-1:0]  cmd_i,
    input  logic [NIB_W-1:0]  alu_res_i,
    input  logic              alu_ovf_i,
    output logic [NIB_W-1:0]  a_o,
    output logic              c_o,
    output logic              s_o,
    output logic [NIB_W-1:0]  b_o,
    output logic [NIB_W-1:0]  x_o,
    output logic [NIB_W-1:0]  spx_o,
    output logic [NIB_W-1:0]  y_o,
    output logic [NIB_W-1:0]  spy_o
);

    logic             cmd_ok;
    logic [CMD_N-1:0] go;

    // A command is accepted only when at most one strobe is high
    always_comb begin
        cmd_ok = ((cmd_i & (cmd_i - CMD_N'(1))) == '0);
        go     = cmd_ok ? cmd_i : '0;
    end

    nib_acc_unit #(.NIB_W(NIB_W)) acc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ld_i    (go[CMD_LD_A]),
        .res_i   (alu_res_i),
        .ovf_i   (alu_ovf_i),
        .rot_l_i (go[CMD_ROT_L]),
        .rot_r_i (go[CMD_ROT_R]),
        .set_c_i (go[CMD_SET_C]),
        .clr_c_i (go[CMD_CLR_C]),
        .tst_c_i (go[CMD_TST_C]),
        .a_o     (a_o),
        .c_o     (c_o),
        .s_o     (s_o)
    );

    nib_plain_reg #(.NIB_W(NIB_W)) breg_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (go[CMD_LD_B]),
        .res_i  (alu_res_i),
        .val_o  (b_o)
    );

    nib_ptr_pair #(.NIB_W(NIB_W), .STEP_EN(1'b0)) xpair_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (go[CMD_LD_X]),
        .res_i  (alu_res_i),
        .xch_i  (go[CMD_XCH_X]),
        .inc_i  (1'b0),
        .dec_i  (1'b0),
        .ptr_o  (x_o),
        .shd_o  (spx_o)
    );

    nib_ptr_pair #(.NIB_W(NIB_W), .STEP_EN(1'b1)) ypair_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (go[CMD_LD_Y]),
        .res_i  (alu_res_i),
        .xch_i  (go[CMD_XCH_Y]),
        .inc_i  (go[CMD_INC_Y]),
        .dec_i  (go[CMD_DEC_Y]),
        .ptr_o  (y_o),
        .shd_o  (spy_o)
    );

endmodule

// File: rtl/nib_regbank_chk.sv
module nib_regbank_chk
    import nib_regbank_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CMD_N-1:0]  cmd_i,
    input logic [NIB_W-1:0]  alu_res_i,
    input logic              alu_ovf_i,
    input logic [NIB_W-1:0]  a_o,
    input logic              c_o,
    input logic              s_o,
    input logic [NIB_W-1:0]  b_o,
    input logic [NIB_W-1:0]  x_o,
    input logic [NIB_W-1:0]  spx_o,
    input logic [NIB_W-1:0]  y_o,
    input logic [NIB_W-1:0]  spy_o
);

    localparam int MSB = NIB_W - 1;

    logic one_cmd;
    assign one_cmd = $onehot(cmd_i);

    AST_LOAD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_LD_A]) |=> (a_o == $past(alu_res_i) && c_o == $past(alu_ovf_i))); // R2

    AST_LOAD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_LD_B]) |=> (b_o == $past(alu_res_i) && $stable(a_o) && $stable(x_o))); // R3

    AST_CARRY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_SET_C]) |=> (c_o && $stable(a_o))); // R4

    AST_CARRY_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_TST_C]) |=> (s_o == $past(c_o))); // R4

    AST_ROT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_ROT_L]) |=> ({c_o, a_o} == {$past(a_o), $past(c_o)})); // R5

    AST_ROT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_ROT_R]) |=> ({a_o, c_o} == {$past(c_o), $past(a_o)})); // R5

    AST_SWAP_FILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_XCH_X]) |=> (x_o == $past(spx_o) && spx_o == $past(x_o))); // R6

    AST_SWAP_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_XCH_Y]) |=> (y_o == $past(spy_o) && spy_o == $past(y_o))); // R7

    AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_INC_Y]) |=> (y_o == NIB_W'($past(y_o) + NIB_W'(1)))); // R8

    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && cmd_i[CMD_DEC_Y]) |=> (y_o == NIB_W'($past(y_o) - NIB_W'(1)))); // R8

    AST_NO_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!one_cmd) |=> ($stable(a_o) && $stable(c_o) && $stable(s_o) && $stable(b_o) &&
                        $stable(x_o) && $stable(spx_o) && $stable(y_o) && $stable(spy_o))); // R9

    AST_ROT_KEEPS_PTRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (one_cmd && (cmd_i[CMD_ROT_L] || cmd_i[CMD_ROT_R])) |=>
        ($stable(y_o) && $stable(x_o) && $stable(b_o) && $stable(s_o))); // R10

    logic msb_unused;
    assign msb_unused = a_o[MSB];

endmodule

bind nib_regbank nib_regbank_chk #(.NIB_W(NIB_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .alu_res_i (alu_res_i),
    .alu_ovf_i (alu_ovf_i),
    .a_o       (a_o),
    .c_o       (c_o),
    .s_o       (s_o),
    .b_o       (b_o),
    .x_o       (x_o),
    .spx_o     (spx_o),
    .y_o       (y_o),
    .spy_o     (spy_o)
);

// File: tb/nib_regbank_tb_top.sv
module nib_regbank_tb_top;

    localparam int W = 4;

    localparam logic [12:0] K_NOP = 13'h0000;
    localparam logic [12:0] K_LDA = 13'h0001;
    localparam logic [12:0] K_LDB = 13'h0002;
    localparam logic [12:0] K_LDX = 13'h0004;
    localparam logic [12:0] K_LDY = 13'h0008;
    localparam logic [12:0] K_XX  = 13'h0010;
    localparam logic [12:0] K_XY  = 13'h0020;
    localparam logic [12:0] K_RL  = 13'h0040;
    localparam logic [12:0] K_RR  = 13'h0080;
    localparam logic [12:0] K_SC  = 13'h0100;
    localparam logic [12:0] K_CC  = 13'h0200;
    localparam logic [12:0] K_TC  = 13'h0400;
    localparam logic [12:0] K_IY  = 13'h0800;
    localparam logic [12:0] K_DY  = 13'h1000;

    // vector: cmd(13) res(4) ovf(1) req(4) | expected a c b x spx y spy s (26)
    localparam int NV = 27;
    localparam logic [47:0] VEC [NV] = '{
        {K_LDA, 4'h9, 1'b1, 4'd2,  4'h9, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R2
        {K_TC,  4'h0, 1'b0, 4'd4,  4'h9, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R4
        {K_RL,  4'h0, 1'b0, 4'd5,  4'h3, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R5
        {K_RR,  4'h0, 1'b0, 4'd5,  4'h9, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R5
        {K_CC,  4'h0, 1'b0, 4'd4,  4'h9, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R4
        {K_RL,  4'h0, 1'b0, 4'd5,  4'h2, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R5
        {K_RR,  4'h0, 1'b0, 4'd5,  4'h9, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R5
        {K_RR,  4'h0, 1'b0, 4'd5,  4'h4, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R5
        {K_TC,  4'h0, 1'b0, 4'd4,  4'h4, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R4
        {K_CC,  4'h0, 1'b0, 4'd4,  4'h4, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1}, // R4
        {K_TC,  4'h0, 1'b0, 4'd4,  4'h4, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R4
        {K_SC,  4'h0, 1'b0, 4'd4,  4'h4, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R4
        {K_LDB, 4'h5, 1'b0, 4'd3,  4'h4, 1'b1, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R3
        {K_LDX, 4'hA, 1'b0, 4'd3,  4'h4, 1'b1, 4'h5, 4'hA, 4'h0, 4'h0, 4'h0, 1'b0}, // R3
        {K_XX,  4'h0, 1'b0, 4'd6,  4'h4, 1'b1, 4'h5, 4'h0, 4'hA, 4'h0, 4'h0, 1'b0}, // R6
        {K_LDX, 4'h3, 1'b0, 4'd3,  4'h4, 1'b1, 4'h5, 4'h3, 4'hA, 4'h0, 4'h0, 1'b0}, // R3
        {K_XX,  4'h0, 1'b0, 4'd6,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'h0, 1'b0}, // R6
        {K_LDY, 4'hF, 1'b1, 4'd3,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}, // R3
        {K_IY,  4'h0, 1'b0, 4'd8,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'h0, 1'b0}, // R8
        {K_DY,  4'h0, 1'b0, 4'd8,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}, // R8
        {K_XY,  4'h0, 1'b0, 4'd7,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'hF, 1'b0}, // R7
        {K_LDY, 4'h1, 1'b0, 4'd3,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'h1, 4'hF, 1'b0}, // R3
        {K_DY,  4'h0, 1'b0, 4'd8,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'hF, 1'b0}, // R8
        {K_XY,  4'h0, 1'b0, 4'd7,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}, // R7
        {K_NOP, 4'h7, 1'b1, 4'd9,  4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}, // R9
        {K_LDA | K_LDB, 4'h7, 1'b0, 4'd9, 4'h4, 1'b1, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}, // R9
        {K_LDA, 4'h0, 1'b0, 4'd10, 4'h0, 1'b0, 4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 1'b0}  // R2, R10
    };

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [12:0]   cmd_i = '0;
    logic [W-1:0]  alu_res_i = '0;
    logic          alu_ovf_i = 1'b0;
    logic [W-1:0]  a_o, b_o, x_o, spx_o, y_o, spy_o;
    logic          c_o, s_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i;

    nib_regbank #(.NIB_W(W)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmd_i     (cmd_i),
        .alu_res_i (alu_res_i),
        .alu_ovf_i (alu_ovf_i),
        .a_o       (a_o),
        .c_o       (c_o),
        .s_o       (s_o),
        .b_o       (b_o),
        .x_o       (x_o),
        .spx_o     (spx_o),
        .y_o       (y_o),
        .spy_o     (spy_o)
    );

    function automatic logic [25:0] snap();
        return {a_o, c_o, b_o, x_o, spx_o, y_o, spy_o, s_o};
    endfunction

    task automatic check(input string req, input logic [25:0] act, input logic [25:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: state actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1", snap(), 26'h0);                       // R1 reset state
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R9", snap(), 26'h0);                       // R9 idle holds

        for (int i = 0; i < NV; i++) begin
            cmd_i     = VEC[i][47:35];
            alu_res_i = VEC[i][34:31];
            alu_ovf_i = VEC[i][30];
            @(negedge clk_i);
            check($sformatf("R%0d step %0d", VEC[i][29:26], i), snap(), VEC[i][25:0]);
        end

        // R8: bus shows the old digit pointer during the step cycle
        cmd_i = K_IY;
        #2;
        check("R8 old value on bus", {22'h0, y_o}, 26'hF);
        @(negedge clk_i);
        check("R8 wrap up", {22'h0, y_o}, 26'h0);

        // R9: three strobes together change nothing
        cmd_i = K_XX | K_XY | K_CC;
        @(negedge clk_i);
        check("R9 multi strobe", snap(), {4'h0, 1'b0, 4'h5, 4'hA, 4'h3, 4'h0, 4'h0, 1'b0});

        // R4 and R10: set carry leaves the accumulator and pointers alone
        cmd_i = K_LDA; alu_res_i = 4'hE; alu_ovf_i = 1'b0;
        @(negedge clk_i);
        cmd_i = K_SC;
        @(negedge clk_i);
        check("R4 set carry", snap(), {4'hE, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'h0, 1'b0});

        // R5: rotate left with carry 1 across a full ring of five
        cmd_i = K_RL;
        repeat (5) @(negedge clk_i);
        check("R5 full ring", snap(), {4'hE, 1'b1, 4'h5, 4'hA, 4'h3, 4'h0, 4'h0, 1'b0});

        // R1: reset in mid-run clears everything
        cmd_i = K_NOP;
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 mid-run reset", snap(), 26'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule